// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block gathers up to eight interrupt sources into one interrupt line. Each source that rises sets a request bit. A mask register hides requests, and an in-service register records which sources have been acknowledged. A per-source auto-clear register decides whether an acknowledge leaves an in-service mark or removes one. When the host runs an acknowledge cycle, the block picks the lowest-numbered request that is pending and not masked. It clears that request and returns the vector programmed for that source one cycle later.

Software programs the block through two write ports. A command write carries an operation code in its upper nibble, a single-bit flag and a source index. A data write goes to whichever target the last preselect command chose: the mask, the auto-clear register or one vector slot. Reads are combinational. The data read port shows one of four registers, chosen by a read-select mode. The status port shows the mode bits, a group-pending flag and the index of the winning source.

Top module: `irq_vec_top`

## Requirements
- R1: After reset the mask is 0xFF. Request, in-service and auto-clear are 0x00. Master mask is on, polled and priority modes are off, the read select is 0, irqOut is low and statusRd reads 0x48.
- R2: A rising edge on srcReq[i] sets request bit i. A falling edge on srcReq[i] clears both request bit i and in-service bit i.
- R3: A source is pending when its request bit is 1 and its mask bit is 0. irqOut is high only when master mask is on, polled mode is off, extIntEn is 1 and at least one source is pending.
- R4: The cycle after ackStrobe, ackValid is high and ackVector holds the vector of the lowest-numbered pending source, whose request bit is cleared. If no source is pending, ackVector is 0.
- R5: On acknowledge, the winner's in-service bit is set when its auto-clear bit is 0, and cleared when its auto-clear bit is 1.
- R6: On a command write, wrData[7:4] is the code. If wrData[3] is 1 the operation touches only bit wrData[2:0]; if it is 0 it touches all bits. Code 2 clears request and mask, code 3 sets mask, code 4 clears request, code 7 clears in-service.
- R7: Code 0 sets the mask to 0xFF and clears request, in-service and auto-clear. It leaves the mode bits unchanged.
- R8: Code 11 sends later data writes to the mask, code 12 to the auto-clear register, and code 14 to vector slot wrData[2:0]. A vector write stores wrData[8:2] and forces bits 1:0 to zero.
- R9: Code 10 sets the read select from wrData[3:2]: 0 selects in-service, 1 mask, 2 request, 3 auto-clear. In the same write, wrData[1:0]=01 turns master mask on and 10 turns it off; other values leave it unchanged.
- R10: Codes 8 and 9 load priority mode from wrData[0] and polled mode from wrData[1].
- R11: statusRd bit 6 is always 1. Bit 5 is priority mode, bit 4 is polled mode and bit 3 is master mask. Bit 7 is set when master mask is on, polled mode is off and a source is pending. Bits 2:0 hold the lowest pending index while bit 7 is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcReq | input | NSRC | Source request levels, edge detected |
| extIntEn | input | 1 | External interrupt enable gating irqOut |
| cmdWr | input | 1 | Command write strobe |
| dataWr | input | 1 | Data write strobe, goes to the preselected target |
| wrData | input | BUS_W | Write data for commands and data writes |
| ackStrobe | input | 1 | Acknowledge request, one cycle |
| ackValid | output | 1 | ackVector is valid this cycle |
| ackVector | output | VEC_W | Vector of the acknowledged source, or 0 |
| dataRd | output | NSRC | Register chosen by the read select |
| statusRd | output | 8 | Status byte |
| irqOut | output | 1 | Interrupt request to the host |

## Verification
A wrong request, mask or in-service bit shows up one cycle after the step that causes it. It appears on irqOut and on the status byte's group flag and index, and the register stays visible through dataRd. A wrong priority pick or a bad vector slot shows up only on the next acknowledge, as a mismatched ackVector. For that reason the stimulus acknowledges with two sources pending at once, and again with nothing pending. An auto-clear fault leaves in-service bits that stay hidden until in-service is selected for reading, so each acknowledge is followed by an explicit read of that register.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int CMD_IDX_W = 3;
  localparam int STAT_W = 8;

  typedef enum logic [3:0] {
    CMD_RESET     = 4'd0,
    CMD_CLR_RQMK  = 4'd2,
    CMD_SET_MASK  = 4'd3,
    CMD_CLR_REQ   = 4'd4,
    CMD_CLR_TOP   = 4'd6,
    CMD_CLR_ISR   = 4'd7,
    CMD_MODE_A    = 4'd8,
    CMD_MODE_B    = 4'd9,
    CMD_CTL_MODE  = 4'd10,
    CMD_SEL_MASK  = 4'd11,
    CMD_SEL_AUTO  = 4'd12,
    CMD_SEL_VEC   = 4'd14
  } cmd_e;

  typedef enum logic [1:0] {
    RD_ISR  = 2'd0,
    RD_MASK = 2'd1,
    RD_REQ  = 2'd2,
    RD_AUTO = 2'd3
  } rdsel_e;

  typedef enum logic [1:0] {
    WP_VEC  = 2'd0,
    WP_MASK = 2'd1,
    WP_AUTO = 2'd2
  } wptr_e;

  typedef struct packed {
    logic                 opReset;
    logic                 opClrReqMask;
    logic                 opSetMask;
    logic                 opClrReq;
    logic                 opClrIsr;
    logic                 single;
    logic [CMD_IDX_W-1:0] idx;
    logic                 wrMask;
    logic                 wrAuto;
    logic                 wrVec;
    logic [CMD_IDX_W-1:0] vecIdx;
  } strobe_t;
endpackage

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdWr,
  input  logic             dataWr,
  input  logic [BUS_W-1:0] wrData,
  output strobe_t          stb,
  output logic             prioMode,
  output logic             pollMode,
  output logic             masterMask,
  output rdsel_e           rdSel
);
  logic [3:0]           code;
  wptr_e                wPtr;
  logic [CMD_IDX_W-1:0] vecPtr;

  assign code = wrData[7:4];

  always_comb begin
    stb        = '0;
    stb.single = wrData[3];
    stb.idx    = wrData[CMD_IDX_W-1:0];
    if (cmdWr) begin
      unique case (code)
        CMD_RESET:    stb.opReset      = 1'b1;
        CMD_CLR_RQMK: stb.opClrReqMask = 1'b1;
        CMD_SET_MASK: stb.opSetMask    = 1'b1;
        CMD_CLR_REQ:  stb.opClrReq     = 1'b1;
        CMD_CLR_ISR:  stb.opClrIsr     = 1'b1;
        default: ;
      endcase
    end
    if (dataWr) begin
      stb.wrMask = (wPtr == WP_MASK);
      stb.wrAuto = (wPtr == WP_AUTO);
      stb.wrVec  = (wPtr == WP_VEC);
    end
    stb.vecIdx = vecPtr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wPtr       <= WP_VEC;
      vecPtr     <= '0;
      prioMode   <= 1'b0;
      pollMode   <= 1'b0;
      masterMask <= 1'b1;
      rdSel      <= RD_ISR;
    end else if (cmdWr) begin
      unique case (code)
        CMD_MODE_A, CMD_MODE_B: begin
          prioMode <= wrData[0];
          pollMode <= wrData[1];
        end
        CMD_CTL_MODE: begin
          rdSel <= rdsel_e'(wrData[3:2]);
          if (wrData[1:0] == 2'b01) masterMask <= 1'b1;
          else if (wrData[1:0] == 2'b10) masterMask <= 1'b0;
        end
        CMD_SEL_MASK: wPtr <= WP_MASK;
        CMD_SEL_AUTO: wPtr <= WP_AUTO;
        CMD_SEL_VEC: begin
          wPtr   <= WP_VEC;
          vecPtr <= wrData[CMD_IDX_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // R6: at most one register operation per command
  p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.opReset, stb.opClrReqMask, stb.opSetMask, stb.opClrReq, stb.opClrIsr}));

  // R8: preselect of mask steers the next data write to the mask only
  p_sel_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWr && code == CMD_SEL_MASK) ##1 (dataWr && !cmdWr) |-> stb.wrMask && !stb.wrVec && !stb.wrAuto);

  // R9: master mask follows the control-mode sub-code
  p_mm_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWr && code == CMD_CTL_MODE && wrData[1:0] == 2'b10) |=> !masterMask);
endmodule

// File: rtl/irq_vec_dp.sv
module irq_vec_dp
  import irq_vec_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int VEC_W = 9,
  parameter int BUS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              stb,
  input  logic [BUS_W-1:0]     wrData,
  input  logic [NSRC-1:0]      srcReq,
  input  logic                 ackStrobe,
  input  rdsel_e               rdSel,
  output logic [NSRC-1:0]      dataRd,
  output logic                 pendAny,
  output logic [CMD_IDX_W-1:0] pendIdx,
  output logic                 ackValid,
  output logic [VEC_W-1:0]     ackVector
);
  logic [NSRC-1:0] reqQ, maskQ, isrQ, acrQ;
  logic [NSRC-1:0] reqN, maskN, isrN, acrN;
  logic [NSRC-1:0] srcPrev, rise, fall, pend, bitSel;
  logic [VEC_W-1:0] vecMem [NSRC];
  logic [CMD_IDX_W-1:0] winIdx;

  assign rise = srcReq & ~srcPrev;
  assign fall = ~srcReq & srcPrev;
  assign pend = reqQ & ~maskQ;
  assign pendAny = |pend;

  always_comb begin
    winIdx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) winIdx = CMD_IDX_W'(i);
    end
  end
  assign pendIdx = winIdx;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      bitSel[i] = !stb.single || (stb.idx == CMD_IDX_W'(i));
    end
  end

  always_comb begin
    reqN  = reqQ;
    maskN = maskQ;
    isrN  = isrQ;
    acrN  = acrQ;
    if (stb.opReset) begin
      maskN = '1;
      reqN  = '0;
      isrN  = '0;
      acrN  = '0;
    end
    if (stb.opClrReqMask) begin
      reqN  = reqN & ~bitSel;
      maskN = maskN & ~bitSel;
    end
    if (stb.opSetMask) maskN = maskN | bitSel;
    if (stb.opClrReq)  reqN  = reqN & ~bitSel;
    if (stb.opClrIsr)  isrN  = isrN & ~bitSel;
    if (stb.wrMask)    maskN = wrData[NSRC-1:0];
    if (stb.wrAuto)    acrN  = wrData[NSRC-1:0];
    if (ackStrobe && pendAny) begin
      reqN[winIdx] = 1'b0;
      isrN[winIdx] = ~acrQ[winIdx];
    end
    reqN = (reqN | rise) & ~fall;
    isrN = isrN & ~fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ    <= '0;
      maskQ   <= '1;
      isrQ    <= '0;
      acrQ    <= '0;
      srcPrev <= '0;
    end else begin
      reqQ    <= reqN;
      maskQ   <= maskN;
      isrQ    <= isrN;
      acrQ    <= acrN;
      srcPrev <= srcReq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) vecMem[i] <= '0;
    end else if (stb.wrVec && (32'(stb.vecIdx) < NSRC)) begin
      vecMem[stb.vecIdx] <= {wrData[VEC_W-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackValid  <= 1'b0;
      ackVector <= '0;
    end else begin
      ackValid  <= ackStrobe;
      ackVector <= (ackStrobe && pendAny) ? vecMem[winIdx] : '0;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_ISR:  dataRd = isrQ;
      RD_MASK: dataRd = maskQ;
      RD_REQ:  dataRd = reqQ;
      default: dataRd = acrQ;
    endcase
  end

  // R4: the winning request is consumed by the acknowledge
  p_ack_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ackStrobe && pendAny && !rise[winIdx]) |=> !reqQ[$past(winIdx)]);

  // R4: acknowledge with nothing pending yields a zero vector
  p_ack_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ackStrobe && !pendAny) |=> ackValid && ackVector == '0);

  // R5: auto-clear source leaves no in-service mark
  p_autoclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ackStrobe && pendAny && acrQ[winIdx] && !stb.opReset) |=> !isrQ[$past(winIdx)]);

  // R2: a released source loses request and in-service
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |=> ((reqQ | isrQ) & $past(fall)) == '0);

  // R7: reset command restores mask and clears status registers
  p_cmd_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.opReset && !ackStrobe && !stb.wrMask && !stb.wrAuto) |=> maskQ == '1 && isrQ == '0 && acrQ == '0);

  // R8: stored vectors are word aligned
  p_vec_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> ackVector[1:0] == 2'b00);
endmodule

// File: rtl/irq_vec_top.sv
module irq_vec_top
  import irq_vec_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int VEC_W = 9,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  srcReq,
  input  logic             extIntEn,
  input  logic             cmdWr,
  input  logic             dataWr,
  input  logic [BUS_W-1:0] wrData,
  input  logic             ackStrobe,
  output logic             ackValid,
  output logic [VEC_W-1:0] ackVector,
  output logic [NSRC-1:0]  dataRd,
  output logic [7:0]       statusRd,
  output logic             irqOut
);
  strobe_t              stb;
  logic                 prioMode, pollMode, masterMask, pendAny, grpPend;
  logic [CMD_IDX_W-1:0] pendIdx;
  rdsel_e               rdSel;

  irq_vec_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdWr(cmdWr), .dataWr(dataWr), .wrData(wrData),
    .stb(stb), .prioMode(prioMode), .pollMode(pollMode),
    .masterMask(masterMask), .rdSel(rdSel)
  );

  irq_vec_dp #(.NSRC(NSRC), .VEC_W(VEC_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData), .srcReq(srcReq),
    .ackStrobe(ackStrobe), .rdSel(rdSel), .dataRd(dataRd), .pendAny(pendAny),
    .pendIdx(pendIdx), .ackValid(ackValid), .ackVector(ackVector)
  );

  assign grpPend  = masterMask && !pollMode && pendAny;
  assign irqOut   = grpPend && extIntEn;
  assign statusRd = {grpPend, 1'b1, prioMode, pollMode, masterMask,
                     grpPend ? pendIdx : {CMD_IDX_W{1'b0}}};

  // R3: the output never rises outside the enabling modes
  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> masterMask && !pollMode && extIntEn && pendAny);

  // R11: a shown index always names a pending group
  p_stat_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRd[2:0] != 3'd0) |-> statusRd[7]);
endmodule

// File: tb/irq_vec_top_tb.sv
module irq_vec_top_tb;
  localparam int NSRC = 8, VEC_W = 9, BUS_W = 16;
  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] srcReq = '0;
  logic extIntEn = 0, cmdWr = 0, dataWr = 0, ackStrobe = 0;
  logic [BUS_W-1:0] wrData = '0;
  logic ackValid, irqOut;
  logic [VEC_W-1:0] ackVector;
  logic [NSRC-1:0] dataRd;
  logic [7:0] statusRd;
  int total = 0, bad = 0;
  bit done = 0;
  logic [VEC_W-1:0] expQ[$];
  string expTag[$];

  always #2 clk = ~clk;

  irq_vec_top #(.NSRC(NSRC), .VEC_W(VEC_W), .BUS_W(BUS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .srcReq(srcReq), .extIntEn(extIntEn),
    .cmdWr(cmdWr), .dataWr(dataWr), .wrData(wrData), .ackStrobe(ackStrobe),
    .ackValid(ackValid), .ackVector(ackVector), .dataRd(dataRd),
    .statusRd(statusRd), .irqOut(irqOut));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [7:0] v);
    @(negedge clk); cmdWr = 1; wrData = {8'h00, v};
    @(negedge clk); cmdWr = 0;
  endtask

  task automatic dat(logic [15:0] v);
    @(negedge clk); dataWr = 1; wrData = v;
    @(negedge clk); dataWr = 0;
  endtask

  task automatic rd(int sel, string tag, int exp);
    cmd(8'hA0 | 8'(sel << 2));
    chk(tag, int'(dataRd), exp);
  endtask

  task automatic src(int i, logic v);
    @(negedge clk); srcReq[i] = v;
    @(negedge clk);
  endtask

  task automatic ack(logic [VEC_W-1:0] exp, string tag);
    @(negedge clk); ackStrobe = 1; expQ.push_back(exp); expTag.push_back(tag);
    @(negedge clk); ackStrobe = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ackValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R4 unexpected ack actual=0x%0h expected=none", ackVector);
      end else begin
        chk(expTag.pop_front(), int'(ackVector), int'(expQ.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", statusRd, 8'h48);
    chk("R1 irq", irqOut, 0);
    rd(0, "R1 isr", 8'h00); rd(1, "R1 mask", 8'hFF);
    rd(2, "R1 req", 8'h00); rd(3, "R1 auto", 8'h00);

    extIntEn = 1;
    src(5, 1); src(2, 1);
    rd(2, "R2 req after rise", 8'h24);
    chk("R3 masked irq", irqOut, 0);
    chk("R11 no group", statusRd, 8'h48);

    cmd(8'hB0); dat(16'h0000);
    rd(1, "R8 mask write", 8'h00);
    chk("R3 irq pending", irqOut, 1);
    chk("R11 group idx", statusRd, 8'hCA);

    cmd(8'hE2); dat(16'h01FF);
    cmd(8'hE5); dat(16'h00A3);

    ack(9'h1FC, "R4 lowest first");
    rd(0, "R5 isr set", 8'h04);
    rd(2, "R4 req consumed", 8'h20);
    chk("R11 idx next", statusRd, 8'hCD);

    cmd(8'hC0); dat(16'h0020);
    ack(9'h0A0, "R8 vector aligned");
    rd(0, "R5 auto-clear", 8'h04);
    chk("R3 idle irq", irqOut, 0);
    ack(9'h000, "R4 none pending");

    src(2, 0);
    rd(0, "R2 fall clears isr", 8'h00);
    src(5, 0);

    src(1, 1);
    chk("R3 irq src1", irqOut, 1);
    @(negedge clk); extIntEn = 0; @(negedge clk);
    chk("R3 ext gate", irqOut, 0);
    extIntEn = 1;

    cmd(8'h82);
    chk("R10 polled status", statusRd, 8'h58);
    chk("R3 polled irq", irqOut, 0);
    cmd(8'h81);
    chk("R10 prio status", statusRd, 8'hE9);
    cmd(8'hA2);
    chk("R9 mm off", statusRd, 8'h60);
    chk("R9 mm off irq", irqOut, 0);
    cmd(8'hA1);
    chk("R9 mm on", statusRd, 8'hE9);

    cmd(8'h39);
    rd(1, "R6 set one mask", 8'h02);
    chk("R6 masked irq", irqOut, 0);
    cmd(8'h40);
    rd(2, "R6 clear all req", 8'h00);
    cmd(8'h30);
    rd(1, "R6 set all mask", 8'hFF);
    cmd(8'h20);
    rd(1, "R6 clear all mask", 8'h00);

    src(3, 1);
    ack(9'h000, "R4 slot3 vector");
    rd(0, "R5 isr3", 8'h08);
    cmd(8'h7B);
    rd(0, "R6 clear one isr", 8'h00);

    cmd(8'h00);
    rd(1, "R7 mask", 8'hFF); rd(3, "R7 auto", 8'h00);
    rd(2, "R7 req", 8'h00); rd(0, "R7 isr", 8'h00);
    chk("R7 modes kept", statusRd, 8'h68);

    cmd(8'h20); cmd(8'h3E);
    rd(1, "R6 single index", 8'h40);

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule